// File: doc/BRIEF.md
# Reserved-Address Identification and Sleep Controller

This block sits beside the byte engine of an I2C target and handles the reserved-address command set. The engine reports START, STOP, each received byte and each acknowledge bit from the master. The block decides whether to ACK or NACK the bytes it owns, supplies the readout bytes, and reports whether the device is asleep. It reads the three select pins to learn its own address.

Identification takes two phases. First, a START is followed by the targeting byte F8h and then by the target's own address byte. After a repeated START, a command byte follows. Command F9h returns a 3-byte identifier. Command CDh returns an 8-byte serial number. Command 86h prepares sleep, and the device falls asleep when the next STOP arrives.

While asleep, the block ignores all traffic except its own address byte. That byte wakes the device, but it is still NACKed. Every later access to the device's own address is also NACKed until a recovery interval, counted in clock cycles, has passed. The identifier, the serial body and the recovery length are parameters. The last serial byte is a CRC that the block computes when it is elaborated.

Top module: `idsleep_ctl`

## Requirements
- R1: A byte F8h arriving as the first byte after a START is ACKed. The byte after it is ACKed only when bits 7:1 equal {DEV_TYPE, sel_pins}, where DEV_TYPE defaults to 4'b1010 and bit 0 is ignored. Any other value is NACKed and ends the sequence. Each decision appears on resp_valid/resp_ack (1 = ACK) one cycle after the rx_valid pulse.
- R2: After a matched targeting phase and a repeated START, a first byte F9h is ACKed. The readout is then DEV_ID, high byte first (00h, 42h by default). Bit 7 of the third byte is 1 exactly when the serial option (SN_EN) is enabled, giving 00h 42h 80h with the option and 00h 42h 00h without it.
- R3: With SN_EN=1, command CDh is ACKed. The readout is the 56-bit SN_BODY, highest byte first, then a CRC byte. The CRC uses polynomial 07h with initial value 00h and is computed MSB first over those seven bytes.
- R4: With SN_EN=0, command CDh is NACKed and no readout starts (tx_valid stays low).
- R5: During a readout, a master ACK advances to the next byte one cycle later. An ACK on the last byte wraps back to the first byte. A master NACK drops tx_valid one cycle later, and later acknowledge bits are ignored.
- R6: A command byte is accepted only as the first byte after the repeated START that follows a matched targeting phase. F9h without that phase, or after a STOP in between, gets no response.
- R7: Command 86h is ACKed. sleep_o rises one cycle after the next STOP. A START that comes before that STOP cancels the request.
- R8: While sleep_o is high, every byte other than the device's own address byte in first position gets no response, F8h included, and no readout starts.
- R9: The own address byte (either R/W value) seen as the first byte while asleep is NACKed. sleep_o then stays high for exactly REC_CYCLES cycles after the clock edge that took the byte. Own address bytes during that interval are NACKed and do not restart it.
- R10: While awake, a first byte that is not a reserved code gets no response from this block.
- R11: After reset, resp_valid, tx_valid, tx_data and sleep_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_pins | input | 3 | Device select pin levels |
| bus_start | input | 1 | One-cycle pulse on START or repeated START |
| bus_stop | input | 1 | One-cycle pulse on STOP |
| rx_valid | input | 1 | One-cycle pulse: a byte from the master is complete |
| rx_data | input | 8 | Received byte, valid with rx_valid |
| mst_ack_valid | input | 1 | One-cycle pulse: master acknowledge bit sampled |
| mst_ack | input | 1 | 1 = master ACK, 0 = master NACK |
| resp_valid | output | 1 | This block has decided on the last byte |
| resp_ack | output | 1 | Decision: 1 = ACK, 0 = NACK |
| tx_valid | output | 1 | A readout byte is being offered |
| tx_data | output | 8 | Readout byte (0 when tx_valid is low) |
| sleep_o | output | 1 | High while asleep or recovering |

## Verification
An ACK/NACK decision is due one cycle after the clock edge that samples rx_valid. The first readout byte appears in that same cycle. Each later readout byte, and the drop of tx_valid after a NACK, is due one cycle after the edge that samples mst_ack_valid. sleep_o is due one cycle after the STOP edge and falls REC_CYCLES edges after the wake byte's edge. The bench drives every input pulse on a falling edge and reads the outputs on the next falling edge, so each check lands half a cycle after the register that produces the result. The recovery window is measured by counting falling edges from that first sample.

// File: rtl/idsleep_ctl.sv
module idsleep_ctl #(
  parameter logic [3:0]  DEV_TYPE   = 4'hA,
  parameter logic [23:0] DEV_ID     = 24'h004200,
  parameter bit          SN_EN      = 1'b1,
  parameter logic [55:0] SN_BODY    = 56'h0000A1B2C3D4E5,
  parameter int          REC_CYCLES = 40000
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel_pins,
  input  logic       bus_start,
  input  logic       bus_stop,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  input  logic       mst_ack_valid,
  input  logic       mst_ack,
  output logic       resp_valid,
  output logic       resp_ack,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  output logic       sleep_o
);

  function automatic logic [7:0] crc8_msb(input logic [55:0] d);
    logic [7:0] c;
    logic       fb;
    c = 8'h00;
    for (int i = 55; i >= 0; i--) begin
      fb = c[7] ^ d[i];
      c  = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return c;
  endfunction

  localparam int          CW      = $clog2(REC_CYCLES + 1);
  localparam logic [7:0]  K_TGT   = 8'hF8;
  localparam logic [7:0]  K_ID    = 8'hF9;
  localparam logic [7:0]  K_SN    = 8'hCD;
  localparam logic [7:0]  K_SLP   = 8'h86;
  localparam logic [63:0] SN_FULL = {SN_BODY, crc8_msb(SN_BODY)};
  localparam logic [23:0] ID_FULL = DEV_ID | (SN_EN ? 24'h000080 : 24'h000000);

  typedef enum logic [2:0] {
    ST_IDLE, ST_TGT, ST_ARMED, ST_CMD, ST_RD, ST_SLPP, ST_SLEEP, ST_REC
  } st_t;

  st_t          st;
  logic         first;
  logic         rd_sn;
  logic [2:0]   idx;
  logic [CW-1:0] rcnt;

  wire        own  = (rx_data[7:1] == {DEV_TYPE, sel_pins});
  wire [2:0]  last = rd_sn ? 3'd7 : 3'd2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      first      <= 1'b0;
      rd_sn      <= 1'b0;
      idx        <= 3'd0;
      rcnt       <= '0;
      resp_valid <= 1'b0;
      resp_ack   <= 1'b0;
    end else begin
      resp_valid <= 1'b0;
      resp_ack   <= 1'b0;
      if (bus_start) begin
        first <= 1'b1;
        case (st)
          ST_ARMED:          st <= ST_CMD;
          ST_SLEEP, ST_REC:  st <= st;
          default:           st <= ST_IDLE;
        endcase
      end else if (bus_stop) begin
        first <= 1'b0;
        case (st)
          ST_SLPP:           st <= ST_SLEEP;
          ST_SLEEP, ST_REC:  st <= st;
          default:           st <= ST_IDLE;
        endcase
      end else if (rx_valid) begin
        first <= 1'b0;
        case (st)
          ST_IDLE, ST_CMD: begin
            st <= ST_IDLE;
            if (first) begin
              if (rx_data == K_TGT) begin
                resp_valid <= 1'b1;
                resp_ack   <= 1'b1;
                st         <= ST_TGT;
              end else if (st == ST_CMD && rx_data == K_ID) begin
                resp_valid <= 1'b1;
                resp_ack   <= 1'b1;
                rd_sn      <= 1'b0;
                idx        <= 3'd0;
                st         <= ST_RD;
              end else if (st == ST_CMD && rx_data == K_SN) begin
                resp_valid <= 1'b1;
                resp_ack   <= SN_EN;
                rd_sn      <= 1'b1;
                idx        <= 3'd0;
                st         <= SN_EN ? ST_RD : ST_IDLE;
              end else if (st == ST_CMD && rx_data == K_SLP) begin
                resp_valid <= 1'b1;
                resp_ack   <= 1'b1;
                st         <= ST_SLPP;
              end
            end
          end
          ST_TGT: begin
            resp_valid <= 1'b1;
            resp_ack   <= own;
            st         <= own ? ST_ARMED : ST_IDLE;
          end
          ST_SLEEP: begin
            if (first && own) begin
              resp_valid <= 1'b1;
              rcnt       <= CW'(REC_CYCLES - 1);
              st         <= ST_REC;
            end
          end
          ST_REC: begin
            if (first && own) resp_valid <= 1'b1;
          end
          default: st <= ST_IDLE;
        endcase
      end else if (mst_ack_valid && st == ST_RD) begin
        if (mst_ack) idx <= (idx == last) ? 3'd0 : idx + 3'd1;
        else         st  <= ST_IDLE;
      end

      if (st == ST_REC) begin
        if (rcnt == '0) st   <= ST_IDLE;
        else            rcnt <= rcnt - 1'b1;
      end
    end
  end

  assign tx_valid = (st == ST_RD);
  assign tx_data  = !tx_valid ? 8'h00 :
                    rd_sn     ? 8'(SN_FULL >> {(3'd7 - idx), 3'b000}) :
                                8'(ID_FULL >> {(3'd2 - idx), 3'b000});
  assign sleep_o  = (st == ST_SLEEP) || (st == ST_REC);

endmodule

// File: rtl/idsleep_ctl_chk.sv
module idsleep_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_start,
  input logic bus_stop,
  input logic rx_valid,
  input logic mst_ack_valid,
  input logic mst_ack,
  input logic resp_valid,
  input logic resp_ack,
  input logic tx_valid,
  input logic sleep_o
);

  a_r1_resp_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(rx_valid));

  a_r9_nack_while_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && sleep_o) |-> !resp_ack);

  a_r7_sleep_entry_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_o) |-> $past(bus_stop));

  a_r8_no_readout_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_o |-> !tx_valid);

  a_r5_nack_ends_readout: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && mst_ack_valid && !mst_ack && !bus_start && !bus_stop && !rx_valid)
      |=> !tx_valid);

endmodule

bind idsleep_ctl idsleep_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
  .rx_valid(rx_valid), .mst_ack_valid(mst_ack_valid), .mst_ack(mst_ack),
  .resp_valid(resp_valid), .resp_ack(resp_ack), .tx_valid(tx_valid),
  .sleep_o(sleep_o)
);

// File: tb/idsleep_ctl_bench.sv
module idsleep_ctl_bench;
  localparam int REC = 50;
  localparam logic [55:0] BODY = 56'h0000A1B2C3D4E5;
  localparam logic [2:0]  SEL  = 3'b101;
  localparam logic [7:0]  OWN  = {4'hA, SEL, 1'b0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_start = 1'b0, bus_stop = 1'b0, rx_valid = 1'b0;
  logic mst_ack_valid = 1'b0, mst_ack = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic [2:0] sel_pins = SEL;
  logic resp_valid, resp_ack, tx_valid, sleep_o;
  logic [7:0] tx_data;
  logic resp_valid2, resp_ack2, tx_valid2, sleep2;
  logic [7:0] tx_data2;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  idsleep_ctl #(.SN_EN(1'b1), .SN_BODY(BODY), .REC_CYCLES(REC)) u_idsleep_ctl (
    .clk(clk), .rst_n(rst_n), .sel_pins(sel_pins), .bus_start(bus_start),
    .bus_stop(bus_stop), .rx_valid(rx_valid), .rx_data(rx_data),
    .mst_ack_valid(mst_ack_valid), .mst_ack(mst_ack), .resp_valid(resp_valid),
    .resp_ack(resp_ack), .tx_valid(tx_valid), .tx_data(tx_data), .sleep_o(sleep_o));

  idsleep_ctl #(.SN_EN(1'b0), .SN_BODY(BODY), .REC_CYCLES(REC)) u_idsleep_ctl_nosn (
    .clk(clk), .rst_n(rst_n), .sel_pins(sel_pins), .bus_start(bus_start),
    .bus_stop(bus_stop), .rx_valid(rx_valid), .rx_data(rx_data),
    .mst_ack_valid(mst_ack_valid), .mst_ack(mst_ack), .resp_valid(resp_valid2),
    .resp_ack(resp_ack2), .tx_valid(tx_valid2), .tx_data(tx_data2), .sleep_o(sleep2));

  function automatic logic [7:0] ref_crc(input logic [55:0] d);
    logic [7:0] c = 8'h00;
    for (int b = 6; b >= 0; b--) begin
      c = c ^ d[b*8 +: 8];
      for (int k = 0; k < 8; k++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
    end
    return c;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_start();
    bus_start = 1'b1; @(negedge clk); bus_start = 1'b0;
  endtask
  task automatic do_stop();
    bus_stop = 1'b1; @(negedge clk); bus_stop = 1'b0;
  endtask
  task automatic do_byte(input logic [7:0] b);
    rx_valid = 1'b1; rx_data = b; @(negedge clk); rx_valid = 1'b0;
  endtask
  task automatic do_mack(input logic a);
    mst_ack_valid = 1'b1; mst_ack = a; @(negedge clk); mst_ack_valid = 1'b0;
  endtask
  task automatic target();
    do_start(); do_byte(8'hF8);
    chk("R1 F8 ack", {resp_valid, resp_ack}, 2'b11);
    do_byte(OWN | 8'h01);
    chk("R1 own addr ack (rw ignored)", {resp_valid, resp_ack}, 2'b11);
  endtask

  task automatic t_reset();
    chk("R11 reset outputs", {resp_valid, tx_valid, tx_data, sleep_o}, 11'h0);
  endtask

  task automatic t_target_miss();
    do_start(); do_byte(8'hF8);
    chk("R1 F8 ack", {resp_valid, resp_ack}, 2'b11);
    do_byte({4'hA, SEL ^ 3'b001, 1'b0});
    chk("R1 foreign addr nack", {resp_valid, resp_ack}, 2'b10);
    do_start(); do_byte(8'hF9);
    chk("R1 dropped after miss", {resp_valid, tx_valid}, 2'b00);
    do_stop();
  endtask

  task automatic t_id();
    target(); do_start(); do_byte(8'hF9);
    chk("R2 F9 ack", {resp_valid, resp_ack, resp_valid2, resp_ack2}, 4'hF);
    chk("R2 id byte0", {tx_valid, tx_data}, {1'b1, 8'h00});
    do_mack(1'b1);
    chk("R2 id byte1", {tx_valid, tx_data}, {1'b1, 8'h42});
    chk("R2 id byte1 no-sn", {tx_valid2, tx_data2}, {1'b1, 8'h42});
    do_mack(1'b1);
    chk("R2 id byte2 sn option", tx_data, 8'h80);
    chk("R2 id byte2 no option", tx_data2, 8'h00);
    do_mack(1'b1);
    chk("R5 wrap to first byte", {tx_valid, tx_data}, {1'b1, 8'h00});
    do_mack(1'b0);
    chk("R5 nack ends readout", {tx_valid, tx_valid2}, 2'b00);
    do_mack(1'b1);
    chk("R5 later ack ignored", {tx_valid, tx_data}, 9'h0);
    do_stop();
  endtask

  task automatic t_sn();
    logic [63:0] full;
    full = {BODY, ref_crc(BODY)};
    target(); do_start(); do_byte(8'hCD);
    chk("R3 CD ack", {resp_valid, resp_ack}, 2'b11);
    chk("R4 CD nack without option", {resp_valid2, resp_ack2, tx_valid2}, 3'b100);
    for (int i = 0; i < 8; i++) begin
      chk($sformatf("R3 serial byte %0d", i), {tx_valid, tx_data}, {1'b1, full[63-8*i -: 8]});
      do_mack(i != 7);
    end
    chk("R5 serial ends on nack", tx_valid, 1'b0);
    do_stop();
  endtask

  task automatic t_untargeted();
    do_start(); do_byte(8'hF9);
    chk("R6 F9 without targeting", {resp_valid, tx_valid}, 2'b00);
    do_stop();
    target(); do_stop(); do_start(); do_byte(8'hF9);
    chk("R6 F9 after stop", {resp_valid, tx_valid}, 2'b00);
    do_stop();
    do_start(); do_byte(8'hA0);
    chk("R10 memory address ignored", {resp_valid, tx_valid}, 2'b00);
    do_stop();
  endtask

  task automatic t_sleep_cancel();
    target(); do_start(); do_byte(8'h86);
    chk("R7 86 ack", {resp_valid, resp_ack}, 2'b11);
    do_start();
    chk("R7 start cancels", sleep_o, 1'b0);
    do_stop();
    chk("R7 no sleep after cancel", sleep_o, 1'b0);
  endtask

  task automatic t_sleep();
    target(); do_start(); do_byte(8'h86);
    chk("R7 awake before stop", sleep_o, 1'b0);
    do_stop();
    chk("R7 sleep after stop", {sleep_o, sleep2}, 2'b11);
    do_start(); do_byte(8'hF8);
    chk("R8 F8 ignored asleep", {resp_valid, tx_valid}, 2'b00);
    do_byte(OWN);
    chk("R8 non-first own byte ignored", {resp_valid, sleep_o}, 2'b01);
    do_start(); do_byte({4'hA, SEL ^ 3'b100, 1'b1});
    chk("R8 foreign select ignored", {resp_valid, sleep_o}, 2'b01);
    do_start(); do_byte(OWN | 8'h01);
    chk("R9 wake byte nacked", {resp_valid, resp_ack, sleep_o}, 3'b101);
    do_start(); do_byte(OWN);
    chk("R9 nack during recovery", {resp_valid, resp_ack, sleep_o}, 3'b101);
    repeat (REC - 3) @(negedge clk);
    chk("R9 still recovering at last cycle", sleep_o, 1'b1);
    @(negedge clk);
    chk("R9 recovery over", sleep_o, 1'b0);
    target();
    do_stop();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_target_miss();
    t_id();
    t_sn();
    t_untargeted();
    t_sleep_cancel();
    t_sleep();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule